// File: doc/BRIEF.md
# I2C Bus Error Detector

This block watches the SCL and SDA lines of an I2C bus. It reports every START and STOP condition with a one-cycle pulse, and it raises a sticky bus-error flag when a condition lands in the middle of a byte frame. Both lines pass through a synchronizer onto the system clock before any edge is taken from them. Inside a frame, a counter tracks completed SCL pulses modulo 9 (8 data bits plus the acknowledge). A START or STOP is correctly placed only when that count is zero.

Role inputs from the surrounding controller gate the error report. An error is flagged only while the device acts as master, or as an addressed slave that is past its address phase. When a START arrives mid-frame while the device is not master, the block also asks the slave logic to restart address recognition. A later stage can then treat that START like any other START.

A pulse counts as complete on the falling SCL edge that follows a rising edge seen inside the frame. Because of this, the SCL rise that sets up a repeated START or a STOP does not shift the count.

Top module: `i2c_bus_guard`

## Requirements
- R1: A falling SDA edge while SCL stays high gives `startPulse` high for exactly one cycle. The pulse appears in the second clock cycle after the SDA change reaches the input pins.
- R2: A rising SDA edge while SCL stays high gives `stopPulse` high for exactly one cycle. `startPulse` and `stopPulse` are never high together.
- R3: SDA changes while SCL is low produce neither pulse.
- R4: The pulse count resets to zero on START. It advances once per complete SCL pulse inside a frame, and it returns to zero after the ninth pulse. A START or STOP that arrives when the count is zero never sets `busErr`.
- R5: A START or STOP inside a frame with a non-zero pulse count sets `busErr` one cycle after the matching detection pulse, when `isMaster` is 1.
- R6: Under the same misplaced condition, `busErr` is set when `isMaster` is 0, `isAddrSlave` is 1 and `inAddrPhase` is 0.
- R7: A misplaced condition leaves `busErr` unchanged when the device is neither master nor an addressed slave. It also leaves `busErr` unchanged when `inAddrPhase` is 1 and `isMaster` is 0.
- R8: `busErr` stays high until a one-cycle `clrErr` pulse clears it. If a new error and `clrErr` fall in the same cycle, the flag stays set.
- R9: `addrRestart` pulses together with `startPulse` only for a misplaced START while `isMaster` is 0. A valid START does not pulse it, and neither does any START while `isMaster` is 1.
- R10: After a STOP, SCL pulses are not counted. A STOP or START that follows while no frame is open does not set `busErr`.
- R11: After reset, `startPulse`, `stopPulse`, `addrRestart` and `busErr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| isMaster | input | 1 | Device currently acts as master |
| isAddrSlave | input | 1 | Device has been addressed as slave |
| inAddrPhase | input | 1 | Slave logic is receiving the address byte |
| clrErr | input | 1 | Write-one-to-clear pulse for the error flag |
| startPulse | output | 1 | One-cycle START detection |
| stopPulse | output | 1 | One-cycle STOP detection |
| busErr | output | 1 | Sticky bus-error flag |
| addrRestart | output | 1 | Request to re-enter address recognition |

## Verification
The assertions check on every cycle that:
- START and STOP never coincide.
- The pulse count stays below nine.
- A STOP closes the frame.
- A rise of `busErr` always follows a detected condition.
- The flag holds without a clear.
- The address-phase slave never sets the error.
- `addrRestart` never appears without a START.

Only the bench scenarios can show the frame arithmetic end to end: byte boundaries after 9 and 18 pulses, a repeated START, and the random mix of roles and bit counts compared against an independent model. They also show the exact two-cycle detection latency and the set-over-clear priority.

// File: rtl/i2c_guard_pkg.sv
package i2c_guard_pkg;
  typedef struct packed {
    logic frameOpen;
    logic frameClose;
    logic pulseArm;
    logic pulseDone;
    logic errSet;
    logic errClr;
  } guardStrobes_t;
endpackage

// File: rtl/i2c_guard_datapath.sv
module i2c_guard_datapath
  import i2c_guard_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int BITS_PER_FRAME = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclIn,
  input  logic          sdaIn,
  input  guardStrobes_t strobes,
  output logic          startDet,
  output logic          stopDet,
  output logic          sclRise,
  output logic          sclFall,
  output logic          inFrame,
  output logic          pulseArmed,
  output logic          cntZero,
  output logic          busErr
);
  localparam int CNT_W = $clog2(BITS_PER_FRAME);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS_PER_FRAME - 1);

  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic sclS, sdaS, sclD, sdaD;
  logic [CNT_W-1:0] pulseCnt;

  // Line synchronizers, idle-high reset so no false edge follows reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh <= '1;
      sdaSh <= '1;
      sclD  <= 1'b1;
      sdaD  <= 1'b1;
    end else begin
      sclSh <= {sclSh[SYNC_STAGES-2:0], sclIn};
      sdaSh <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
      sclD  <= sclS;
      sdaD  <= sdaS;
    end
  end

  assign sclS     = sclSh[SYNC_STAGES-1];
  assign sdaS     = sdaSh[SYNC_STAGES-1];
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign cntZero  = (pulseCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt   <= '0;
      inFrame    <= 1'b0;
      pulseArmed <= 1'b0;
    end else begin
      if (strobes.frameOpen || strobes.frameClose) begin
        pulseCnt   <= '0;
        pulseArmed <= 1'b0;
        inFrame    <= strobes.frameOpen;
      end else if (strobes.pulseDone) begin
        pulseCnt   <= (pulseCnt == LAST) ? '0 : pulseCnt + 1'b1;
        pulseArmed <= 1'b0;
      end else if (strobes.pulseArm) begin
        pulseArmed <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                busErr <= 1'b0;
    else if (strobes.errSet)  busErr <= 1'b1;
    else if (strobes.errClr)  busErr <= 1'b0;
  end

  a_r2_start_stop_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(startDet && stopDet));
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= LAST);
  a_r10_stop_closes_frame: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (!inFrame && cntZero));
  a_r5_err_needs_condition: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busErr) |-> $past(startDet || stopDet));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (busErr && !strobes.errClr) |=> busErr);
endmodule

// File: rtl/i2c_guard_control.sv
module i2c_guard_control
  import i2c_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          startDet,
  input  logic          stopDet,
  input  logic          sclRise,
  input  logic          sclFall,
  input  logic          inFrame,
  input  logic          pulseArmed,
  input  logic          cntZero,
  input  logic          isMaster,
  input  logic          isAddrSlave,
  input  logic          inAddrPhase,
  input  logic          clrErr,
  output guardStrobes_t strobes,
  output logic          addrRestart
);
  logic misplaced, involved;

  assign misplaced = (startDet | stopDet) & inFrame & ~cntZero;
  assign involved  = isMaster | (isAddrSlave & ~inAddrPhase);

  always_comb begin
    strobes            = '0;
    strobes.frameOpen  = startDet;
    strobes.frameClose = stopDet;
    strobes.pulseArm   = sclRise & inFrame;
    strobes.pulseDone  = sclFall & inFrame & pulseArmed;
    strobes.errSet     = misplaced & involved;
    strobes.errClr     = clrErr;
  end

  assign addrRestart = startDet & inFrame & ~cntZero & ~isMaster;

  a_r7_addr_phase_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!isMaster && inAddrPhase) |-> !strobes.errSet);
  a_r9_restart_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    addrRestart |-> (startDet && !isMaster));
endmodule

// File: rtl/i2c_bus_guard.sv
module i2c_bus_guard
  import i2c_guard_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int BITS_PER_FRAME = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic isMaster,
  input  logic isAddrSlave,
  input  logic inAddrPhase,
  input  logic clrErr,
  output logic startPulse,
  output logic stopPulse,
  output logic busErr,
  output logic addrRestart
);
  guardStrobes_t strobes;
  logic sclRise, sclFall, inFrame, pulseArmed, cntZero;

  i2c_guard_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .BITS_PER_FRAME(BITS_PER_FRAME)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strobes(strobes),
    .startDet(startPulse), .stopDet(stopPulse), .sclRise(sclRise),
    .sclFall(sclFall), .inFrame(inFrame), .pulseArmed(pulseArmed),
    .cntZero(cntZero), .busErr(busErr)
  );

  i2c_guard_control uControl (
    .clk(clk), .rstN(rstN), .startDet(startPulse), .stopDet(stopPulse),
    .sclRise(sclRise), .sclFall(sclFall), .inFrame(inFrame),
    .pulseArmed(pulseArmed), .cntZero(cntZero), .isMaster(isMaster),
    .isAddrSlave(isAddrSlave), .inAddrPhase(inAddrPhase), .clrErr(clrErr),
    .strobes(strobes), .addrRestart(addrRestart)
  );
endmodule

// File: tb/sim_i2c_bus_guard.sv
module sim_i2c_bus_guard;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, sclIn, sdaIn, isMaster, isAddrSlave, inAddrPhase, clrErr;
  logic startPulse, stopPulse, busErr, addrRestart;

  i2c_bus_guard u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .isMaster(isMaster),
    .isAddrSlave(isAddrSlave), .inAddrPhase(inAddrPhase), .clrErr(clrErr),
    .startPulse(startPulse), .stopPulse(stopPulse), .busErr(busErr),
    .addrRestart(addrRestart)
  );

  int tests = 0, fails = 0;
  int nStart = 0, nStop = 0, nRestart = 0, nBoth = 0;
  int eStart = 0, eStop = 0, eRestart = 0;
  bit mScl = 1, mSda = 1, mFrame = 0, mArmed = 0, mErr = 0;
  int mCnt = 0;
  bit done = 0;

  always @(negedge clk) if (rstN) begin
    nStart   += int'(startPulse);
    nStop    += int'(stopPulse);
    nRestart += int'(addrRestart);
    nBoth    += int'(startPulse && stopPulse);
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit involvedF(bit m, bit a, bit ap);
    return m | (a & ~ap);
  endfunction

  // Independent bus model: update for one line change
  task automatic modelEdge(bit c, bit d);
    bit mis;
    mis = mFrame && (mCnt != 0);
    if (mScl && c && mSda && !d) begin
      eStart++;
      if (mis && involvedF(isMaster, isAddrSlave, inAddrPhase)) mErr = 1;
      if (mis && !isMaster) eRestart++;
      mFrame = 1; mCnt = 0; mArmed = 0;
    end else if (mScl && c && !mSda && d) begin
      eStop++;
      if (mis && involvedF(isMaster, isAddrSlave, inAddrPhase)) mErr = 1;
      mFrame = 0; mCnt = 0; mArmed = 0;
    end else if (mFrame && !mScl && c) begin
      mArmed = 1;
    end else if (mFrame && mScl && !c && mArmed) begin
      mCnt = (mCnt + 1) % 9; mArmed = 0;
    end
    mScl = c; mSda = d;
  endtask

  task automatic setLines(bit c, bit d);
    @(negedge clk);
    sclIn = c; sdaIn = d;
    modelEdge(c, d);
    repeat (4) @(negedge clk);
  endtask

  task automatic genStart;
    setLines(0, mSda); setLines(0, 1); setLines(1, 1); setLines(1, 0); setLines(0, 0);
  endtask
  task automatic genStop;
    setLines(0, mSda); setLines(0, 0); setLines(1, 0); setLines(1, 1);
  endtask
  task automatic genBit(bit d);
    setLines(0, mSda); setLines(0, d); setLines(1, d);
  endtask
  task automatic genBits(int n);
    for (int i = 0; i < n; i++) genBit(1'($urandom));
  endtask

  task automatic setRoles(bit m, bit a, bit ap);
    @(negedge clk);
    isMaster = m; isAddrSlave = a; inAddrPhase = ap;
  endtask

  task automatic clearErr;
    @(negedge clk); clrErr = 1;
    @(negedge clk); clrErr = 0;
    @(negedge clk);
    mErr = 0;
    check("R8 clear", int'(busErr), 0);
  endtask

  task automatic checkAll(string tag);
    check({tag, " R1 starts"}, nStart, eStart);
    check({tag, " R2 stops"}, nStop, eStop);
    check({tag, " R9 restarts"}, nRestart, eRestart);
    check({tag, " R5/R6/R7 busErr"}, int'(busErr), int'(mErr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 0; sclIn = 1; sdaIn = 1; isMaster = 0; isAddrSlave = 0;
    inAddrPhase = 0; clrErr = 0;
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11 startPulse", int'(startPulse), 0);
    check("R11 stopPulse", int'(stopPulse), 0);
    check("R11 busErr", int'(busErr), 0);
    check("R11 addrRestart", int'(addrRestart), 0);
    rstN = 1;
    repeat (3) @(negedge clk);

    // R10 idle STOP and START with no open frame
    setRoles(1, 0, 0);
    genStop; checkAll("R10 idle stop");
    check("R10 no err", int'(busErr), 0);

    // R4 exact byte boundary, then repeated START after 18 pulses
    genStart; genBits(9); genStop; checkAll("R4 one byte");
    check("R4 boundary stop", int'(busErr), 0);
    genStart; genBits(18); genStart; checkAll("R4 repeated start");
    check("R4 boundary restart", int'(busErr), 0);
    genStop;

    // R3 SDA toggles with SCL low create no conditions
    genStart;
    for (int i = 0; i < 6; i++) setLines(0, 1'(i));
    checkAll("R3 low toggles");
    genBits(9); genStop;

    // R5 master misplaced STOP
    genStart; genBits(3); genStop; checkAll("R5 master stop");
    check("R5 set", int'(busErr), 1);
    clearErr;

    // R6 addressed slave misplaced START, also R9 restart request
    setRoles(0, 1, 0);
    genStart; genBits(4); genStart; checkAll("R6 slave start");
    check("R6 set", int'(busErr), 1);
    check("R9 pulse", nRestart, 1);
    clearErr;
    genStop;

    // R7 not involved, and address phase
    setRoles(0, 0, 0);
    genStart; genBits(5); genStop; checkAll("R7 uninvolved");
    check("R7 no err", int'(busErr), 0);
    setRoles(0, 1, 1);
    genStart; genBits(2); genStart; checkAll("R7 addr phase");
    check("R7 no err addr", int'(busErr), 0);
    genBits(9); genStop;

    // R10 pulses after STOP not counted
    setRoles(1, 0, 0);
    genBits(5); genStop; genStart; checkAll("R10 after stop");
    check("R10 no err", int'(busErr), 0);

    // R1 exact latency and R8 set-over-clear priority
    genBit(1); genBit(1);
    @(negedge clk);
    sdaIn = 0; modelEdge(1, 0);
    @(negedge clk);
    check("R1 not yet", int'(startPulse), 0);
    @(negedge clk);
    check("R1 pulse", int'(startPulse), 1);
    clrErr = 1;
    @(negedge clk);
    clrErr = 0;
    check("R1 one cycle", int'(startPulse), 0);
    check("R8 set wins", int'(busErr), 1);
    repeat (3) @(negedge clk);
    checkAll("R1 directed");
    clearErr;

    // Random mix
    for (int it = 0; it < 40; it++) begin
      setRoles(1'($urandom), 1'($urandom), 1'($urandom));
      genStart; checkAll("rand start");
      genBits(int'($urandom_range(0, 20)));
      if ($urandom_range(0, 1) == 1) begin
        genStop; checkAll("rand stop");
      end
      if ($urandom_range(0, 3) == 0) clearErr;
    end
    genStop; checkAll("final");
    check("R2 exclusive", nBoth, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule